// File: doc/BRIEF.md
# Key-Locked DRAM Controller Configuration Registers

This block is the software-visible register space of a DRAM controller. It sits on a simple word-wide bus with write and read strobes, a byte address, and 32-bit write and read data. Every access is a full 32-bit word. It models only what software sees. It does not generate DRAM commands, train a PHY or run ECC.

Word 0 is a protection register that acts as a key gate. A small state machine tracks it. The machine has two states, LOCKED and OPEN, and reset puts it in LOCKED. The transition KEY_OK moves it to OPEN, from either state, when exactly 0xFC600309 is written to word 0. The transition KEY_BAD moves it to LOCKED, from either state, when any other value is written to word 0. While the machine is LOCKED, writes to all other words are dropped, and each dropped write is flagged by a single-cycle error pulse.

Accepted writes pass through a merge stage before they are stored:
- The configuration word has read-only fields that are forced from parameters: a hardware version and an encoded memory size.
- The PHY status word never reports busy.
- The self-test control word always reports that a test finished and passed.

Top module: `memctl_keyreg`

## Requirements
- R1: A write to byte offset 0x00 stores an unlock flag. The flag is 1 when the data is exactly 0xFC600309 and 0 otherwise. Reading offset 0x00 returns the flag in bit 0, with all other bits 0.
- R2: While the flag is 0, a write to any in-range word other than word 0 leaves that word unchanged. `wr_err` is 1 for exactly the one cycle after that write. Writes to word 0 never raise `wr_err`.
- R3: A write to the configuration word (offset 0x04) first clears the data bits under mask 0xF00FC04C. It then ORs in the fixed value: version `HW_VER` in bits 31:28, bit 19 set, bits 3:2 = 3, and the size code in bits 1:0.
- R4: The size code maps `MEM_MB` values 128, 256, 512 and 1024 to 0, 1, 2 and 3. Any other value gives code 2.
- R5: A write to the PHY status word (offset 0x60) clears bit 0. When `PLL_FORCE` is 1, the write also sets bit 4.
- R6: A write to the self-test word (offset 0x70) sets bit 12 and clears bit 13.
- R7: After reset, every word reads 0 except the configuration word, which reads its fixed value (0x1008000E with default parameters). The block starts locked.
- R8: Word indices 64 and above (byte offsets 0x100 and up) read as 0. A write to them changes nothing and raises `wr_err` one cycle later.
- R9: Address bits 1:0 are ignored. The word index is `addr[ADDR_W-1:2]`.
- R10: `rdata` is registered. It shows the addressed word one cycle after `rd_en` and holds its value while `rd_en` is low. In the OPEN state, a write to any other word stores the merged data (the data unchanged for plain words) and raises no error. A later read returns the stored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one word |
| rd_en | input | 1 | Read strobe for one word |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| wr_err | output | 1 | One-cycle pulse for a dropped or out-of-range write |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume that the inputs are held at zero during reset. Under these assumptions, every read result follows from the writes that came before it, in order. The stimulus keeps to this by issuing one operation per task call, each with a single strobe, and by leaving every bus input at zero until reset is released. The random mix is weighted toward word 0, the three special words, and the out-of-range space. This makes lock and unlock transitions, blocked writes and error pulses frequent.

// File: rtl/memctl_keyreg_pkg.sv
package memctl_keyreg_pkg;

    localparam int WORD_W = 32;
    localparam logic [WORD_W-1:0] UNLOCK_KEY   = 32'hFC60_0309;
    localparam logic [WORD_W-1:0] CONF_RO_MASK = 32'hF00F_C04C;
    localparam logic [WORD_W-1:0] CONF_CONST   = 32'h0008_000C;

    localparam int IDX_PROT     = 0;
    localparam int IDX_CONF     = 1;
    localparam int IDX_PHYSTAT  = 24;
    localparam int IDX_SELFTEST = 28;

    localparam int PHY_BUSY_BIT  = 0;
    localparam int PLL_LOCK_BIT  = 4;
    localparam int TEST_DONE_BIT = 12;
    localparam int TEST_FAIL_BIT = 13;

    typedef enum logic [0:0] {
        ST_LOCKED = 1'b0,
        ST_OPEN   = 1'b1
    } lock_state_t;

    function automatic logic [1:0] size_code(int mb);
        case (mb)
            128:     return 2'd0;
            256:     return 2'd1;
            512:     return 2'd2;
            1024:    return 2'd3;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] conf_fixed(int ver, int mb);
        logic [WORD_W-1:0] v;
        v = WORD_W'(ver & 15) << 28;
        return v | CONF_CONST | {30'b0, size_code(mb)};
    endfunction

endpackage

// File: rtl/memctl_keyreg_lock.sv
module memctl_keyreg_lock
    import memctl_keyreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic prot_wr,
    input  logic key_match,
    output logic open_o
);

    lock_state_t state_q;
    lock_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (prot_wr && key_match)  state_d = ST_OPEN;    // KEY_OK
            ST_OPEN:   if (prot_wr && !key_match) state_d = ST_LOCKED;  // KEY_BAD
            default:   state_d = ST_LOCKED;
        endcase
    end

    always_comb begin
        open_o = (state_q == ST_OPEN);
    end

endmodule

// File: rtl/memctl_keyreg_decode.sv
module memctl_keyreg_decode #(
    parameter int ADDR_W    = 12,
    parameter int NUM_WORDS = 64,
    localparam int IDX_W    = $clog2(NUM_WORDS),
    localparam int FULL_W   = ADDR_W - 2
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              open_i,
    output logic [IDX_W-1:0]  idx,
    output logic              in_range,
    output logic              is_prot,
    output logic              accept,
    output logic              reject
);

    logic [FULL_W-1:0] full_idx;
    logic [1:0]        unused_lsb;

    assign unused_lsb = addr[1:0];
    assign full_idx   = addr[ADDR_W-1:2];
    assign in_range   = (full_idx < FULL_W'(NUM_WORDS));
    assign idx        = full_idx[IDX_W-1:0];
    assign is_prot    = in_range && (idx == '0);
    assign accept     = wr_en && in_range && !is_prot && open_i;
    assign reject     = wr_en && (!in_range || (!is_prot && !open_i));

endmodule

// File: rtl/memctl_keyreg_merge.sv
module memctl_keyreg_merge
    import memctl_keyreg_pkg::*;
#(
    parameter int HW_VER    = 1,
    parameter int MEM_MB    = 512,
    parameter bit PLL_FORCE = 1'b1,
    parameter int IDX_W     = 6
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);

    localparam logic [WORD_W-1:0] FIXED = conf_fixed(HW_VER, MEM_MB);

    logic [WORD_W-1:0] stat_v;

    generate
        if (PLL_FORCE) begin : g_pll_on
            always_comb begin
                stat_v = din;
                stat_v[PHY_BUSY_BIT] = 1'b0;
                stat_v[PLL_LOCK_BIT] = 1'b1;
            end
        end else begin : g_pll_off
            always_comb begin
                stat_v = din;
                stat_v[PHY_BUSY_BIT] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        dout = din;
        if (idx == IDX_W'(IDX_CONF)) begin
            dout = (din & ~CONF_RO_MASK) | FIXED;
        end else if (idx == IDX_W'(IDX_PHYSTAT)) begin
            dout = stat_v;
        end else if (idx == IDX_W'(IDX_SELFTEST)) begin
            dout[TEST_DONE_BIT] = 1'b1;
            dout[TEST_FAIL_BIT] = 1'b0;
        end
    end

endmodule

// File: rtl/memctl_keyreg_store.sv
module memctl_keyreg_store
    import memctl_keyreg_pkg::*;
#(
    parameter int                NUM_WORDS = 64,
    parameter int                IDX_W     = 6,
    parameter logic [WORD_W-1:0] CONF_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [WORD_W-1:0] rword
);

    logic [WORD_W-1:0] words [NUM_WORDS];

    // Word 0 is held by the lock state machine, not here.
    assign words[0] = '0;

    generate
        for (genvar g = 1; g < NUM_WORDS; g++) begin : g_word
            localparam logic [WORD_W-1:0] INIT = (g == IDX_CONF) ? CONF_INIT : '0;
            always_ff @(posedge clk) begin
                if (!rst_n)                         words[g] <= INIT;
                else if (we && widx == IDX_W'(g))   words[g] <= wdata;
            end
        end
    endgenerate

    assign rword = words[ridx];

endmodule

// File: rtl/memctl_keyreg.sv
module memctl_keyreg
    import memctl_keyreg_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_WORDS = 64,
    parameter int HW_VER    = 1,
    parameter int MEM_MB    = 512,
    parameter bit PLL_FORCE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              wr_err
);

    localparam int IDX_W = $clog2(NUM_WORDS);
    localparam logic [WORD_W-1:0] CONF_RESET = conf_fixed(HW_VER, MEM_MB);

    logic             lock_open;
    logic [IDX_W-1:0] idx;
    logic             in_range;
    logic             is_prot;
    logic             accept;
    logic             reject;
    logic [31:0]      merged;
    logic [31:0]      rword;

    memctl_keyreg_decode #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_decode (
        .wr_en    (wr_en),
        .addr     (addr),
        .open_i   (lock_open),
        .idx      (idx),
        .in_range (in_range),
        .is_prot  (is_prot),
        .accept   (accept),
        .reject   (reject)
    );

    memctl_keyreg_lock u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .prot_wr   (wr_en && is_prot),
        .key_match (wdata == UNLOCK_KEY),
        .open_o    (lock_open)
    );

    memctl_keyreg_merge #(
        .HW_VER(HW_VER), .MEM_MB(MEM_MB), .PLL_FORCE(PLL_FORCE), .IDX_W(IDX_W)
    ) u_merge (
        .idx  (idx),
        .din  (wdata),
        .dout (merged)
    );

    memctl_keyreg_store #(
        .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .CONF_INIT(CONF_RESET)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (accept),
        .widx  (idx),
        .wdata (merged),
        .ridx  (idx),
        .rword (rword)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            wr_err <= 1'b0;
        end else begin
            wr_err <= reject;
            if (rd_en) begin
                if (!in_range)    rdata <= '0;
                else if (is_prot) rdata <= {31'b0, lock_open};
                else              rdata <= rword;
            end
        end
    end

endmodule

// File: rtl/memctl_keyreg_chk.sv
module memctl_keyreg_chk
    import memctl_keyreg_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_WORDS = 64,
    parameter int HW_VER    = 1,
    parameter int MEM_MB    = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic              wr_err,
    input logic              unlocked
);

    localparam logic [31:0] FIX  = conf_fixed(HW_VER, MEM_MB);
    localparam logic [1:0]  CODE = size_code(MEM_MB);

    logic [ADDR_W-3:0] widx;
    logic              oob;
    assign widx = addr[ADDR_W-1:2];
    assign oob  = (widx >= (ADDR_W-2)'(NUM_WORDS));

    p_key_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == '0 && wdata == UNLOCK_KEY) |=> unlocked);

    p_key_close_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && widx == '0 && wdata != UNLOCK_KEY) |=> !unlocked);

    p_locked_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !unlocked && widx != '0) |=> wr_err);

    p_err_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_en) && ($past(!unlocked) || $past(oob)));

    p_conf_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && widx == (ADDR_W-2)'(IDX_CONF)) |=>
        ((rdata & CONF_RO_MASK) == (FIX & CONF_RO_MASK)) && ((rdata[1:0] & CODE) == CODE));

    p_oob_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && oob) |=> wr_err);

    p_oob_rd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && oob) |=> rdata == '0);

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

bind memctl_keyreg memctl_keyreg_chk #(
    .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .HW_VER(HW_VER), .MEM_MB(MEM_MB)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .wr_err   (wr_err),
    .unlocked (lock_open)
);

// File: tb/test_memctl_keyreg.sv
module test_memctl_keyreg;

    localparam int AW = 12;
    localparam logic [31:0] KEY = 32'hFC60_0309;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_big, rdata_odd;
    logic        wr_err, err_big, err_odd;

    int checks = 0;
    int errors = 0;

    logic [31:0] mdl [64];
    logic        mdl_open;

    always #2 clk = ~clk;

    memctl_keyreg i_memctl_keyreg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .wr_err(wr_err));

    memctl_keyreg #(.HW_VER(3), .MEM_MB(1024), .PLL_FORCE(1'b0)) i_big (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata_big), .wr_err(err_big));

    memctl_keyreg #(.MEM_MB(300)) i_odd (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata_odd), .wr_err(err_odd));

    function automatic logic [31:0] fixed_of(int ver, int code);
        return (32'(ver) << 28) | (32'd1 << 19) | (32'd3 << 2) | 32'(code);
    endfunction

    function automatic logic [31:0] merge_of(int idx, logic [31:0] d, int ver, int code, bit pll);
        logic [31:0] r;
        r = d;
        if (idx == 1) begin
            r = d & ~(32'hF000_0000 | 32'h0008_0000 | 32'h0007_C000 | 32'h40 | 32'hC);
            r = r | fixed_of(ver, code);
        end else if (idx == 24) begin
            r[0] = 1'b0;
            if (pll) r[4] = 1'b1;
        end else if (idx == 28) begin
            r[12] = 1'b1;
            r[13] = 1'b0;
        end
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic do_write(logic [AW-1:0] a, logic [31:0] d, string tag);
        int idx;
        bit exp_err;
        idx = int'(a[AW-1:2]);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        exp_err = (idx >= 64) || (idx != 0 && !mdl_open);
        if (idx == 0) mdl_open = (d == KEY);
        else if (!exp_err) mdl[idx] = merge_of(idx, d, 1, 2, 1'b1);
        check(tag, {31'b0, wr_err}, {31'b0, exp_err});
    endtask

    task automatic do_read(logic [AW-1:0] a, string tag);
        int idx;
        logic [31:0] exp;
        idx = int'(a[AW-1:2]);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        if (idx >= 64)     exp = '0;
        else if (idx == 0) exp = {31'b0, mdl_open};
        else               exp = mdl[idx];
        check(tag, rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd2718);
        for (int i = 0; i < 64; i++) mdl[i] = '0;
        mdl[1] = fixed_of(1, 2);
        mdl_open = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset contents and lock state
        for (int i = 0; i < 64; i++) do_read(AW'(i * 4), "R7 reset word");
        do_read(12'h004, "R7 conf reset");
        check("R4 conf code 3 ver 3", rdata_big, fixed_of(3, 3));
        check("R4 unsupported size falls back", rdata_odd, fixed_of(1, 2));

        // R2: locked write dropped with pulse
        do_write(12'h004, 32'h0000_0000, "R2 locked err");
        do_read(12'h004, "R2 conf unchanged");
        do_write(12'h020, 32'h1234_5678, "R2 locked err plain");
        do_read(12'h020, "R2 plain unchanged");
        do_write(12'h000, 32'hFC60_0308, "R1 bad key no err");
        do_read(12'h000, "R1 bad key stays locked");
        do_write(12'h000, KEY, "R1 key no err");
        do_read(12'h000, "R1 key opens");

        // R3
        do_write(12'h004, 32'hFFFF_FFFF, "R3 write ones");
        do_read(12'h004, "R3 merge ones");
        do_write(12'h004, 32'h0000_0000, "R3 write zero");
        do_read(12'h004, "R3 merge zero");
        check("R4 big conf code after write", rdata_big, fixed_of(3, 3));

        // R5
        do_write(12'h060, 32'hFFFF_FFFF, "R5 write");
        do_read(12'h060, "R5 busy cleared");
        do_write(12'h060, 32'h0000_0000, "R5 write zero");
        do_read(12'h060, "R5 pll forced");
        check("R5 no pll force", rdata_big, 32'h0);

        // R6
        do_write(12'h070, 32'hFFFF_FFFF, "R6 write");
        do_read(12'h070, "R6 fail cleared");
        do_write(12'h070, 32'h0, "R6 write zero");
        do_read(12'h070, "R6 done set");

        // R8
        do_write(12'h100, 32'hDEAD_BEEF, "R8 oob write err");
        do_read(12'h100, "R8 oob read zero");
        do_read(12'hFFC, "R8 top oob read zero");

        // R9
        do_write(12'h00B, 32'hA5A5_0F0F, "R9 unaligned write");
        do_read(12'h008, "R9 aligned readback");
        do_read(12'h00A, "R9 unaligned readback");

        // R10: hold when no strobe
        do_read(12'h008, "R10 read");
        @(negedge clk);
        addr = 12'h004;
        @(negedge clk);
        check("R10 rdata holds", rdata, mdl[2]);

        // Relock and confirm blocking
        do_write(12'h000, 32'h0, "R1 relock");
        do_write(12'h008, 32'h0, "R2 blocked after relock");
        do_read(12'h008, "R2 value kept");

        // Random mix
        for (int n = 0; n < 600; n++) begin
            int sel;
            logic [AW-1:0] a;
            logic [31:0] d;
            sel = int'($urandom % 8);
            case (sel)
                0: a = 12'h000;
                1: a = 12'h004;
                2: a = 12'h060;
                3: a = 12'h070;
                4: a = AW'(12'h100 + ($urandom % 12'hF00));
                default: a = AW'(($urandom % 64) * 4);
            endcase
            a[1:0] = 2'($urandom);
            d = $urandom;
            if (sel == 0 && ($urandom % 2) == 0) d = KEY;
            if (($urandom % 2) == 0) do_write(a, d, "R10 random write");
            else                     do_read(a, "R10 random read");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule